// File: doc/BRIEF.md
# Nested Trap Sequencer

This block tracks how deeply a CPU core is nested in trap handlers and drives the privilege and instruction-pointer changes that go with each entry and return. Each cycle it samples the running instruction pointer and privilege level, a hardware interrupt request, an exception request, a return-from-handler strobe and a flag saying whether other cores are running. When it accepts a trap, it saves the running context into a shadow slot of its own for that nesting level. A hardware interrupt, a first exception and a double exception each have their own slot. It then issues a one-cycle redirect that carries the handler entry and an all-ones privilege. The handler entry comes from a vector input.

On a return it issues a redirect that restores the context saved at the current level. An exception raised inside the exception handler becomes a double exception. An exception raised inside the double handler is a triple fault, and the core stops for good. Before stopping it sends a one-cycle broadcast, but only when other cores are active.

The sequencer has five states. NORMAL means no handler is running. IN_HWINT is the hardware interrupt handler, IN_EXC the exception handler and IN_DOUBLE the double-exception handler. SHUTDOWN means halted. The named transitions are: take-hw (NORMAL to IN_HWINT), take-exc (NORMAL or IN_HWINT to IN_EXC), take-double (IN_EXC to IN_DOUBLE), triple (IN_DOUBLE to SHUTDOWN), ret-hw (IN_HWINT to NORMAL), ret-exc (IN_EXC to NORMAL, or to IN_HWINT when the exception interrupted a hardware handler) and ret-double (IN_DOUBLE to IN_EXC).

Top module: `trap_nest_ctrl`

## Requirements
- R1: After reset, `state_o` reads NORMAL, and `redir_valid`, `halted` and `triple_bcast` are all low. The `state_o` encoding is NORMAL=0, IN_HWINT=1, IN_EXC=2, IN_DOUBLE=3, SHUTDOWN=4. Every effect of inputs sampled at a clock edge shows on the outputs right after that edge. `redir_valid` is high for exactly that one cycle.
- R2: In NORMAL, a `hw_irq` with no `exc_req` saves `cur_ip` and `cur_priv` in the hardware slot and moves to IN_HWINT. It redirects to `hw_vec` (zero-extended) with an all-ones privilege. A later `iret` in IN_HWINT redirects to the saved IP and privilege and moves to NORMAL.
- R3: In NORMAL, an `exc_req` saves the context in the exception slot and moves to IN_EXC. It redirects to `exc_vec` (zero-extended) with an all-ones privilege.
- R4: An `iret` in IN_EXC redirects to the IP and privilege in the exception slot. It moves to NORMAL if the exception was taken from NORMAL.
- R5: `hw_irq` is ignored in IN_HWINT, IN_EXC and IN_DOUBLE. The state does not change and no redirect is issued.
- R6: An `exc_req` in IN_EXC is a double exception. It saves the context in the double slot and moves to IN_DOUBLE. It redirects to `exc_vec` with an all-ones privilege.
- R7: An `iret` in IN_DOUBLE redirects to the double slot's IP and privilege and moves to IN_EXC. The exception slot keeps its contents.
- R8: An `exc_req` in IN_DOUBLE while `others_active` is 1 raises `triple_bcast` for exactly one cycle and moves to SHUTDOWN with `halted` high.
- R9: An `exc_req` in IN_DOUBLE while `others_active` is 0 moves to SHUTDOWN with `halted` high and never raises `triple_bcast`.
- R10: SHUTDOWN is left only by reset. In SHUTDOWN every request is ignored: no redirect and no broadcast.
- R11: Inputs that arrive in the same cycle are ranked exception first, then return, then hardware interrupt.
- R12: An `exc_req` in IN_HWINT is taken as an ordinary exception. Its `iret` restores the exception slot and moves to IN_HWINT. The next `iret` then restores the hardware slot.
- R13: An `iret` in NORMAL is ignored. There is no redirect and the state stays NORMAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_ip | input | IP_W | Running instruction pointer |
| cur_priv | input | PRIV_W | Running privilege level |
| hw_irq | input | 1 | Hardware interrupt request |
| hw_vec | input | VEC_W | Hardware interrupt handler entry |
| exc_req | input | 1 | Exception event |
| exc_vec | input | VEC_W | Exception handler entry |
| iret | input | 1 | Return-from-handler strobe |
| others_active | input | 1 | Other cores are running |
| redir_valid | output | 1 | Load the redirect IP and privilege this cycle |
| redir_ip | output | IP_W | New instruction pointer |
| redir_priv | output | PRIV_W | New privilege level |
| state_o | output | 3 | Nesting state |
| triple_bcast | output | 1 | One-cycle triple-fault broadcast |
| halted | output | 1 | Core stopped |

## Verification
Some rules are checked by the assertions on every cycle. Handlers block hardware interrupts. Every accepted exception raises privilege to all ones. Exceptions escalate from IN_EXC to IN_DOUBLE and from IN_DOUBLE to SHUTDOWN. The broadcast depends on `others_active` and lasts one cycle, and the halt is sticky. Whether a return restores exactly the values saved at its own level can only be shown by the bench's scenarios. The same holds for the return to IN_HWINT after a nested exception and for the priority among simultaneous inputs. The bench drives each of these with a sweep of distinct IP, privilege and vector values.

// File: rtl/trap_nest_pkg.sv
`timescale 1ns/1ps
package trap_nest_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL    = 3'd0,
        ST_IN_HWINT  = 3'd1,
        ST_IN_EXC    = 3'd2,
        ST_IN_DOUBLE = 3'd3,
        ST_SHUTDOWN  = 3'd4
    } nest_state_e;

    typedef enum logic [2:0] {
        ACT_NONE     = 3'd0,
        ACT_TAKE_HW  = 3'd1,
        ACT_TAKE_EXC = 3'd2,
        ACT_TAKE_DBL = 3'd3,
        ACT_RET_HW   = 3'd4,
        ACT_RET_EXC  = 3'd5,
        ACT_RET_DBL  = 3'd6,
        ACT_TRIPLE   = 3'd7
    } nest_act_e;

    localparam int SLOT_HW   = 0;
    localparam int SLOT_EXC  = 1;
    localparam int SLOT_DBL  = 2;
    localparam int NUM_SLOTS = 3;

endpackage

// File: rtl/nest_fsm.sv
`timescale 1ns/1ps
module nest_fsm
    import trap_nest_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hw_irq,
    input  logic        exc_req,
    input  logic        iret,
    input  logic        others_active,
    output nest_state_e state_q,
    output nest_act_e   act,
    output logic        triple_bcast,
    output logic        halted
);

    nest_state_e state_d;
    logic        hw_under_exc_q;
    logic        hw_under_exc_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q        <= ST_NORMAL;
            hw_under_exc_q <= 1'b0;
        end else begin
            state_q        <= state_d;
            hw_under_exc_q <= hw_under_exc_d;
        end
    end

    // Next state and action; exception outranks return, return outranks interrupt
    always_comb begin
        state_d        = state_q;
        act            = ACT_NONE;
        hw_under_exc_d = hw_under_exc_q;
        unique case (state_q)
            ST_NORMAL: begin
                if (exc_req) begin
                    act            = ACT_TAKE_EXC;
                    state_d        = ST_IN_EXC;
                    hw_under_exc_d = 1'b0;
                end else if (hw_irq) begin
                    act     = ACT_TAKE_HW;
                    state_d = ST_IN_HWINT;
                end
            end
            ST_IN_HWINT: begin
                if (exc_req) begin
                    act            = ACT_TAKE_EXC;
                    state_d        = ST_IN_EXC;
                    hw_under_exc_d = 1'b1;
                end else if (iret) begin
                    act     = ACT_RET_HW;
                    state_d = ST_NORMAL;
                end
            end
            ST_IN_EXC: begin
                if (exc_req) begin
                    act     = ACT_TAKE_DBL;
                    state_d = ST_IN_DOUBLE;
                end else if (iret) begin
                    act            = ACT_RET_EXC;
                    state_d        = hw_under_exc_q ? ST_IN_HWINT : ST_NORMAL;
                    hw_under_exc_d = 1'b0;
                end
            end
            ST_IN_DOUBLE: begin
                if (exc_req) begin
                    act     = ACT_TRIPLE;
                    state_d = ST_SHUTDOWN;
                end else if (iret) begin
                    act     = ACT_RET_DBL;
                    state_d = ST_IN_EXC;
                end
            end
            ST_SHUTDOWN: begin
                state_d = ST_SHUTDOWN;
            end
            default: begin
                state_d = ST_SHUTDOWN;
            end
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            triple_bcast <= 1'b0;
            halted       <= 1'b0;
        end else begin
            triple_bcast <= (act == ACT_TRIPLE) && others_active;
            halted       <= (state_d == ST_SHUTDOWN);
        end
    end

endmodule

// File: rtl/shadow_slot.sv
`timescale 1ns/1ps
module shadow_slot #(
    parameter int IP_W   = 32,
    parameter int PRIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              save,
    input  logic [IP_W-1:0]   ip_in,
    input  logic [PRIV_W-1:0] priv_in,
    output logic [IP_W-1:0]   ip_q,
    output logic [PRIV_W-1:0] priv_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_q   <= '0;
            priv_q <= '0;
        end else if (save) begin
            ip_q   <= ip_in;
            priv_q <= priv_in;
        end
    end

endmodule

// File: rtl/redirect_unit.sv
`timescale 1ns/1ps
module redirect_unit
    import trap_nest_pkg::*;
#(
    parameter int IP_W   = 32,
    parameter int PRIV_W = 8,
    parameter int VEC_W  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  nest_act_e                         act,
    input  logic [VEC_W-1:0]                  hw_vec,
    input  logic [VEC_W-1:0]                  exc_vec,
    input  logic [NUM_SLOTS-1:0][IP_W-1:0]    slot_ip,
    input  logic [NUM_SLOTS-1:0][PRIV_W-1:0]  slot_priv,
    output logic                              redir_valid,
    output logic [IP_W-1:0]                   redir_ip,
    output logic [PRIV_W-1:0]                 redir_priv
);

    localparam logic [PRIV_W-1:0] PRIV_MAX = {PRIV_W{1'b1}};
    localparam int                PAD_W    = IP_W - VEC_W;

    logic              nxt_valid;
    logic [IP_W-1:0]   nxt_ip;
    logic [PRIV_W-1:0] nxt_priv;

    always_comb begin
        nxt_valid = 1'b1;
        nxt_ip    = '0;
        nxt_priv  = PRIV_MAX;
        unique case (act)
            ACT_TAKE_HW:  nxt_ip = {{PAD_W{1'b0}}, hw_vec};
            ACT_TAKE_EXC,
            ACT_TAKE_DBL: nxt_ip = {{PAD_W{1'b0}}, exc_vec};
            ACT_RET_HW: begin
                nxt_ip   = slot_ip[SLOT_HW];
                nxt_priv = slot_priv[SLOT_HW];
            end
            ACT_RET_EXC: begin
                nxt_ip   = slot_ip[SLOT_EXC];
                nxt_priv = slot_priv[SLOT_EXC];
            end
            ACT_RET_DBL: begin
                nxt_ip   = slot_ip[SLOT_DBL];
                nxt_priv = slot_priv[SLOT_DBL];
            end
            default: nxt_valid = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid <= 1'b0;
            redir_ip    <= '0;
            redir_priv  <= '0;
        end else begin
            redir_valid <= nxt_valid;
            redir_ip    <= nxt_ip;
            redir_priv  <= nxt_priv;
        end
    end

endmodule

// File: rtl/trap_nest_ctrl.sv
`timescale 1ns/1ps
module trap_nest_ctrl
    import trap_nest_pkg::*;
#(
    parameter int IP_W   = 32,
    parameter int PRIV_W = 8,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IP_W-1:0]   cur_ip,
    input  logic [PRIV_W-1:0] cur_priv,
    input  logic              hw_irq,
    input  logic [VEC_W-1:0]  hw_vec,
    input  logic              exc_req,
    input  logic [VEC_W-1:0]  exc_vec,
    input  logic              iret,
    input  logic              others_active,
    output logic              redir_valid,
    output logic [IP_W-1:0]   redir_ip,
    output logic [PRIV_W-1:0] redir_priv,
    output logic [2:0]        state_o,
    output logic              triple_bcast,
    output logic              halted
);

    nest_state_e                      state_q;
    nest_act_e                        act;
    logic [NUM_SLOTS-1:0]             save_vec;
    logic [NUM_SLOTS-1:0][IP_W-1:0]   slot_ip;
    logic [NUM_SLOTS-1:0][PRIV_W-1:0] slot_priv;

    nest_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .hw_irq        (hw_irq),
        .exc_req       (exc_req),
        .iret          (iret),
        .others_active (others_active),
        .state_q       (state_q),
        .act           (act),
        .triple_bcast  (triple_bcast),
        .halted        (halted)
    );

    assign save_vec[SLOT_HW]  = (act == ACT_TAKE_HW);
    assign save_vec[SLOT_EXC] = (act == ACT_TAKE_EXC);
    assign save_vec[SLOT_DBL] = (act == ACT_TAKE_DBL);

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        shadow_slot #(
            .IP_W   (IP_W),
            .PRIV_W (PRIV_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .save    (save_vec[k]),
            .ip_in   (cur_ip),
            .priv_in (cur_priv),
            .ip_q    (slot_ip[k]),
            .priv_q  (slot_priv[k])
        );
    end

    redirect_unit #(
        .IP_W   (IP_W),
        .PRIV_W (PRIV_W),
        .VEC_W  (VEC_W)
    ) u_redir (
        .clk         (clk),
        .rst_n       (rst_n),
        .act         (act),
        .hw_vec      (hw_vec),
        .exc_vec     (exc_vec),
        .slot_ip     (slot_ip),
        .slot_priv   (slot_priv),
        .redir_valid (redir_valid),
        .redir_ip    (redir_ip),
        .redir_priv  (redir_priv)
    );

    assign state_o = state_q;

endmodule

// File: rtl/trap_nest_chk.sv
`timescale 1ns/1ps
module trap_nest_chk #(
    parameter int PRIV_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_irq,
    input logic              exc_req,
    input logic              iret,
    input logic              others_active,
    input logic              redir_valid,
    input logic [PRIV_W-1:0] redir_priv,
    input logic [2:0]        state_o,
    input logic              triple_bcast,
    input logic              halted
);

    localparam logic [2:0] S_NORMAL = 3'd0;
    localparam logic [2:0] S_HWINT  = 3'd1;
    localparam logic [2:0] S_EXC    = 3'd2;
    localparam logic [2:0] S_DBL    = 3'd3;
    localparam logic [2:0] S_DOWN   = 3'd4;

    AST_EXC_RAISES_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_NORMAL && exc_req) |=> (redir_valid && redir_priv == {PRIV_W{1'b1}} && state_o == S_EXC)); // R3
    AST_HW_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == S_EXC || state_o == S_DBL) && hw_irq && !exc_req && !iret) |=> (!redir_valid && $stable(state_o))); // R5
    AST_DOUBLE_ESCALATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_EXC && exc_req) |=> (state_o == S_DBL && redir_priv == {PRIV_W{1'b1}})); // R6
    AST_TRIPLE_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_DBL && exc_req && others_active) |=> (triple_bcast && halted)); // R8
    AST_TRIPLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_DBL && exc_req && !others_active) |=> (!triple_bcast && halted)); // R9
    AST_BCAST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        triple_bcast |=> !triple_bcast); // R8
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && state_o == S_DOWN && !redir_valid)); // R10
    AST_NORMAL_RET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_NORMAL && iret && !exc_req && !hw_irq) |=> (!redir_valid && state_o == S_NORMAL)); // R13
    AST_HWINT_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == S_HWINT && hw_irq && !exc_req && !iret) |=> (!redir_valid && state_o == S_HWINT)); // R5

endmodule

bind trap_nest_ctrl trap_nest_chk #(.PRIV_W(PRIV_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hw_irq        (hw_irq),
    .exc_req       (exc_req),
    .iret          (iret),
    .others_active (others_active),
    .redir_valid   (redir_valid),
    .redir_priv    (redir_priv),
    .state_o       (state_o),
    .triple_bcast  (triple_bcast),
    .halted        (halted)
);

// File: tb/trap_nest_ctrl_test.sv
`timescale 1ns/1ps
module trap_nest_ctrl_test;

    localparam int IP_W   = 8;
    localparam int PRIV_W = 3;
    localparam int VEC_W  = 4;
    localparam int PMAX   = (1 << PRIV_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [IP_W-1:0]   cur_ip = '0;
    logic [PRIV_W-1:0] cur_priv = '0;
    logic              hw_irq = 1'b0;
    logic [VEC_W-1:0]  hw_vec = '0;
    logic              exc_req = 1'b0;
    logic [VEC_W-1:0]  exc_vec = '0;
    logic              iret = 1'b0;
    logic              others_active = 1'b0;
    logic              redir_valid;
    logic [IP_W-1:0]   redir_ip;
    logic [PRIV_W-1:0] redir_priv;
    logic [2:0]        state_o;
    logic              triple_bcast;
    logic              halted;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    trap_nest_ctrl #(.IP_W(IP_W), .PRIV_W(PRIV_W), .VEC_W(VEC_W)) uut (
        .clk(clk), .rst_n(rst_n), .cur_ip(cur_ip), .cur_priv(cur_priv),
        .hw_irq(hw_irq), .hw_vec(hw_vec), .exc_req(exc_req), .exc_vec(exc_vec),
        .iret(iret), .others_active(others_active), .redir_valid(redir_valid),
        .redir_ip(redir_ip), .redir_priv(redir_priv), .state_o(state_o),
        .triple_bcast(triple_bcast), .halted(halted)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input logic h, input logic e, input logic r, input logic o,
                        input int ip, input int pr, input int hv, input int ev);
        hw_irq        = h;
        exc_req       = e;
        iret          = r;
        others_active = o;
        cur_ip        = ip[IP_W-1:0];
        cur_priv      = pr[PRIV_W-1:0];
        hw_vec        = hv[VEC_W-1:0];
        exc_vec       = ev[VEC_W-1:0];
        @(posedge clk);
        #1;
        hw_irq  = 1'b0;
        exc_req = 1'b0;
        iret    = 1'b0;
    endtask

    task automatic redir(input string req, input int st, input int ip, input int pr);
        chk(req, "state", int'(state_o), st);
        chk(req, "redir_valid", int'(redir_valid), 1);
        chk(req, "redir_ip", int'(redir_ip), ip);
        chk(req, "redir_priv", int'(redir_priv), pr);
    endtask

    task automatic quiet(input string req, input int st);
        chk(req, "state", int'(state_o), st);
        chk(req, "redir_valid", int'(redir_valid), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        chk("R1", "state", int'(state_o), 0);
        chk("R1", "redir_valid", int'(redir_valid), 0);
        chk("R1", "halted", int'(halted), 0);
        chk("R1", "triple_bcast", int'(triple_bcast), 0);
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();

        // R2, R5, R13: hardware interrupt entry and return
        for (int i = 0; i < 16; i++) begin
            int ipa = (i * 13 + 5) % 256;
            int pa  = i % 8;
            step(1, 0, 0, 0, ipa, pa, i, 0);
            redir("R2", 1, i, PMAX);
            step(1, 0, 0, 0, ipa ^ 255, 0, (i + 3) % 16, 0);
            quiet("R5", 1);
            step(0, 0, 1, 0, 0, 0, 0, 0);
            redir("R2", 0, ipa, pa);
            step(0, 0, 1, 0, 0, 0, 0, 0);
            quiet("R13", 0);
        end

        // R3, R4, R5, R6, R7: exception, double exception and their returns
        for (int i = 0; i < 16; i++) begin
            int ipa = i * 7 + 1;
            int pa  = (i + 2) % 8;
            int ipb = (i * 29 + 100) % 256;
            int pb  = (i + 5) % 8;
            step(0, 1, 0, 0, ipa, pa, 0, i);
            redir("R3", 2, i, PMAX);
            step(1, 0, 0, 0, 0, 0, 5, 0);
            quiet("R5", 2);
            step(0, 1, 0, 0, ipb, pb, 0, 15 - i);
            redir("R6", 3, 15 - i, PMAX);
            step(1, 0, 0, 0, 0, 0, 6, 0);
            quiet("R5", 3);
            step(0, 0, 1, 0, 0, 0, 0, 0);
            redir("R7", 2, ipb, pb);
            step(0, 0, 1, 0, 0, 0, 0, 0);
            redir("R4", 0, ipa, pa);
        end

        // R12: exception inside a hardware handler
        step(1, 0, 0, 0, 40, 2, 9, 0);
        redir("R12", 1, 9, PMAX);
        step(0, 1, 0, 0, 50, 7, 0, 3);
        redir("R12", 2, 3, PMAX);
        step(0, 0, 1, 0, 0, 0, 0, 0);
        redir("R12", 1, 50, 7);
        step(0, 0, 1, 0, 0, 0, 0, 0);
        redir("R12", 0, 40, 2);

        // R11: same-cycle priority
        step(1, 1, 1, 0, 60, 1, 5, 11);
        redir("R11", 2, 11, PMAX);
        step(1, 0, 1, 0, 0, 0, 5, 0);
        redir("R11", 0, 60, 1);
        step(0, 1, 0, 0, 70, 4, 0, 2);
        step(1, 1, 1, 0, 71, 5, 6, 8);
        redir("R11", 3, 8, PMAX);

        // R8, R9, R10: triple fault with and without other cores
        for (int o = 0; o < 2; o++) begin
            do_reset();
            step(0, 1, 0, 0, 10, 1, 0, 1);
            step(0, 1, 0, 0, 20, 2, 0, 2);
            step(0, 1, 0, o, 30, 3, 0, 3);
            chk(o == 1 ? "R8" : "R9", "state", int'(state_o), 4);
            chk(o == 1 ? "R8" : "R9", "halted", int'(halted), 1);
            chk(o == 1 ? "R8" : "R9", "triple_bcast", int'(triple_bcast), o);
            chk(o == 1 ? "R8" : "R9", "redir_valid", int'(redir_valid), 0);
            step(0, 0, 0, o, 0, 0, 0, 0);
            chk("R8", "triple_bcast after one cycle", int'(triple_bcast), 0);
            for (int k = 0; k < 8; k++) begin
                step(k[0], k[1], k[2], 1'b1, k, k, k, k);
                quiet("R10", 4);
                chk("R10", "halted", int'(halted), 1);
                chk("R10", "triple_bcast", int'(triple_bcast), 0);
            end
        end
        do_reset();

        finish_run();
    end

endmodule